// File: doc/BRIEF.md
# Timestep Barrier Controller

This block keeps a mesh of spiking cores in lock-step on a shared discrete timestep. Each core works through its neuron groups and then raises a one-cycle "finished" report. Once every participating core has reported, the controller does not release the mesh immediately. It first enters a drain phase. That phase holds until every spike message injected into the mesh has reached its destination. Only then does it issue a separate step phase, a one-cycle broadcast that tells every participating core to move from timestep t to t+1 and begin its next update pass.

Spike traffic is seen as per-core, per-cycle injection and delivery pulses. The controller sums these into one global in-flight count. A participation mask removes idle cores from the barrier. Two kinds of misuse raise a sticky protocol fault: a core injecting spikes after it has reported finished, and more deliveries than spikes in flight.

Top module: `timestep_barrier`

## Requirements
- R1: While reset is high and in the cycle after it is released, `phase` is 0, `timestep` is 0, `advance` is all zero and `proto_err` is 0.
- R2: `phase` encodes RUN=0, GATHER=1, DRAIN=2, STEP=3. A finished report from an enabled core is recorded at the clock edge where it is seen. At the next edge the controller leaves RUN for GATHER, or for DRAIN when that report completes the set.
- R3: One edge after the last enabled core's report is recorded, `phase` becomes DRAIN. Cores whose `core_en` bit is 0 are not waited for. An all-zero mask counts as a complete set.
- R4: The in-flight count changes each cycle by the number of set `spike_inj` bits minus the number of set `spike_dlv` bits. DRAIN holds while the count is nonzero. It moves to STEP at the first edge that finds the count at zero.
- R5: STEP lasts exactly one cycle and is followed by RUN. During STEP, `advance[i]` is 1 for every enabled core and 0 for every disabled core. Outside STEP, `advance` is all zero.
- R6: `timestep` increments by one at the edge that ends STEP, modulo 2^TS_W (TS_W defaults to 32). It holds at every other edge. All finished records are cleared at that same edge.
- R7: Certain finished reports have no effect on `phase`: a second report from a core already recorded in the current timestep, a report from a disabled core, and a report arriving during the STEP cycle.
- R8: A `spike_inj` bit from an enabled core whose finished report is already recorded sets `proto_err`. Injections from cores that have not reported do not set it. `proto_err` stays set until reset.
- R9: A cycle whose deliveries exceed the in-flight count plus that cycle's injections sets `proto_err` and leaves the in-flight count at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_en | input | N_CORES | Participation mask, one bit per core |
| core_done | input | N_CORES | Per-core finished report pulse |
| spike_inj | input | N_CORES | Per-core spike injection pulse |
| spike_dlv | input | N_CORES | Per-core spike delivery pulse |
| advance | output | N_CORES | Per-core timestep-advance pulse |
| timestep | output | TS_W | Current timestep |
| phase | output | 2 | Controller phase code |
| proto_err | output | 1 | Sticky protocol fault |

## Verification
The bench exercises two situations in which separate functions fall in the same cycle. In the first, spike injections and deliveries arrive together in one cycle. The bench judges this by counting the deliveries still needed to leave DRAIN, which must equal the net count of injected spikes. In the second, finished reports are driven during the STEP cycle itself, where clearing the records and recording a report collide. The bench checks that the phase remains RUN afterwards. Both cases are provoked for every one of the fifteen non-empty masks of a four-core configuration. The expected phase, advance vector and timestep are derived from the mask's population count and a running barrier tally.

// File: rtl/ts_pkg.sv
package ts_pkg;

    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_GATHER = 2'd1,
        PH_DRAIN  = 2'd2,
        PH_STEP   = 2'd3
    } phase_e;

    typedef struct packed {
        logic any_done;
        logic all_done;
    } gather_t;

    function automatic phase_e step_phase(input phase_e cur, input gather_t g, input logic drained);
        phase_e nxt;
        nxt = cur;
        case (cur)
            PH_RUN: begin
                if (g.all_done)      nxt = PH_DRAIN;
                else if (g.any_done) nxt = PH_GATHER;
            end
            PH_GATHER: if (g.all_done) nxt = PH_DRAIN;
            PH_DRAIN:  if (drained)    nxt = PH_STEP;
            PH_STEP:   nxt = PH_RUN;
            default:   nxt = PH_RUN;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/ts_done_tracker.sv
module ts_done_tracker
    import ts_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CORES-1:0] core_en,
    input  logic [N_CORES-1:0] core_done,
    input  logic [N_CORES-1:0] spike_inj,
    input  logic               clear,
    output gather_t            gather,
    output logic               late_inj
);
    logic [N_CORES-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || clear) seen_q <= '0;
        else              seen_q <= seen_q | (core_done & core_en);
    end

    always_comb begin
        gather.all_done = &(seen_q | ~core_en);
        gather.any_done = |(seen_q & core_en);
        late_inj        = |(spike_inj & seen_q & core_en);
    end
endmodule

// File: rtl/ts_flight_counter.sv
module ts_flight_counter #(
    parameter int N_CORES  = 4,
    parameter int FLIGHT_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_CORES-1:0]  spike_inj,
    input  logic [N_CORES-1:0]  spike_dlv,
    output logic [FLIGHT_W-1:0] in_flight,
    output logic                drained,
    output logic                underflow
);
    localparam int CW = $clog2(N_CORES + 1);

    logic [CW-1:0]       n_in;
    logic [CW-1:0]       n_out;
    logic [FLIGHT_W:0]   sum;

    always_comb begin
        n_in  = '0;
        n_out = '0;
        for (int i = 0; i < N_CORES; i++) begin
            n_in  = n_in  + CW'(spike_inj[i]);
            n_out = n_out + CW'(spike_dlv[i]);
        end
    end

    assign sum       = {1'b0, in_flight} + (FLIGHT_W+1)'(n_in);
    assign underflow = sum < (FLIGHT_W+1)'(n_out);
    assign drained   = (in_flight == '0);

    always_ff @(posedge clk) begin
        if (rst || underflow) in_flight <= '0;
        else                  in_flight <= FLIGHT_W'(sum - (FLIGHT_W+1)'(n_out));
    end
endmodule

// File: rtl/ts_barrier_fsm.sv
module ts_barrier_fsm
    import ts_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int TS_W    = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CORES-1:0] core_en,
    input  gather_t            gather,
    input  logic               drained,
    output phase_e             phase_q,
    output logic [TS_W-1:0]    ts_q,
    output logic [N_CORES-1:0] advance,
    output logic               clear_seen
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
            ts_q    <= '0;
        end else begin
            phase_q <= step_phase(phase_q, gather, drained);
            if (phase_q == PH_STEP) ts_q <= ts_q + 1'b1;
        end
    end

    assign clear_seen = (phase_q == PH_STEP);
    assign advance    = {N_CORES{clear_seen}} & core_en;
endmodule

// File: rtl/timestep_barrier.sv
module timestep_barrier
    import ts_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int TS_W     = 32,
    parameter int FLIGHT_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CORES-1:0] core_en,
    input  logic [N_CORES-1:0] core_done,
    input  logic [N_CORES-1:0] spike_inj,
    input  logic [N_CORES-1:0] spike_dlv,
    output logic [N_CORES-1:0] advance,
    output logic [TS_W-1:0]    timestep,
    output logic [1:0]         phase,
    output logic               proto_err
);
    gather_t             gather;
    logic                late_inj;
    logic                clear_seen;
    logic [FLIGHT_W-1:0] in_flight;
    logic                drained;
    logic                underflow;
    phase_e              phase_q;

    ts_done_tracker #(.N_CORES(N_CORES)) u_track (
        .clk(clk), .rst(rst), .core_en(core_en), .core_done(core_done),
        .spike_inj(spike_inj), .clear(clear_seen), .gather(gather), .late_inj(late_inj)
    );

    ts_flight_counter #(.N_CORES(N_CORES), .FLIGHT_W(FLIGHT_W)) u_flight (
        .clk(clk), .rst(rst), .spike_inj(spike_inj), .spike_dlv(spike_dlv),
        .in_flight(in_flight), .drained(drained), .underflow(underflow)
    );

    ts_barrier_fsm #(.N_CORES(N_CORES), .TS_W(TS_W)) u_fsm (
        .clk(clk), .rst(rst), .core_en(core_en), .gather(gather), .drained(drained),
        .phase_q(phase_q), .ts_q(timestep), .advance(advance), .clear_seen(clear_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else     proto_err <= proto_err | late_inj | underflow;
    end

    assign phase = phase_q;
endmodule

// File: rtl/ts_barrier_chk.sv
module ts_barrier_chk #(
    parameter int N_CORES  = 4,
    parameter int TS_W     = 32,
    parameter int FLIGHT_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          phase,
    input logic [N_CORES-1:0]  advance,
    input logic [TS_W-1:0]     timestep,
    input logic                proto_err,
    input logic [FLIGHT_W-1:0] in_flight
);
    assert_step_single_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3) |=> (phase == 2'd0));

    assert_advance_only_in_step_R5: assert property (@(posedge clk) disable iff (rst)
        (advance != '0) |-> (phase == 2'd3));

    assert_step_after_drain_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3) |-> ($past(phase) == 2'd2));

    assert_drain_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && in_flight != '0) |=> (phase == 2'd2));

    assert_ts_increment_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3) |=> (timestep == $past(timestep) + 1'b1));

    assert_ts_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> $stable(timestep));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
endmodule

bind timestep_barrier ts_barrier_chk #(
    .N_CORES(N_CORES), .TS_W(TS_W), .FLIGHT_W(FLIGHT_W)
) u_chk (
    .clk(clk), .rst(rst), .phase(phase), .advance(advance),
    .timestep(timestep), .proto_err(proto_err), .in_flight(in_flight)
);

// File: tb/timestep_barrier_test.sv
module timestep_barrier_test;
    localparam int N = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst;
    logic [N-1:0] en, done, inj, dlv;
    logic [N-1:0] advance, advance_w;
    logic [31:0]  timestep;
    logic [2:0]   ts_w;
    logic [1:0]   phase, phase_w;
    logic         err, err_w;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_ts = 0;
    bit finished = 0;

    timestep_barrier #(.N_CORES(N), .TS_W(32), .FLIGHT_W(8)) uut (
        .clk(clk), .rst(rst), .core_en(en), .core_done(done), .spike_inj(inj),
        .spike_dlv(dlv), .advance(advance), .timestep(timestep), .phase(phase), .proto_err(err)
    );

    timestep_barrier #(.N_CORES(N), .TS_W(3), .FLIGHT_W(8)) uut_wrap (
        .clk(clk), .rst(rst), .core_en(en), .core_done(done), .spike_inj(inj),
        .spike_dlv(dlv), .advance(advance_w), .timestep(ts_w), .phase(phase_w), .proto_err(err_w)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 4'hF; done = '0; inj = '0; dlv = '0;
        tick(); tick(); tick();
        chk("R1 phase in reset", 64'(phase), 0);
        rst = 1'b0;
        tick();
        chk("R1 phase", 64'(phase), 0);
        chk("R1 timestep", 64'(timestep), 0);
        chk("R1 advance", 64'(advance), 0);
        chk("R1 proto_err", 64'(err), 0);

        for (int m = 1; m < 16; m++) begin
            int k;
            int seen;
            k = $countones(m[N-1:0]);
            seen = 0;
            en = m[N-1:0];
            // net in-flight after these two cycles equals k
            inj = m[N-1:0]; tick();
            inj = m[N-1:0]; dlv = m[N-1:0]; tick();
            inj = '0; dlv = '0;
            for (int i = 0; i < N; i++) begin
                if (m[i]) begin
                    done = N'(1 << i); tick(); done = '0; tick();
                    seen++;
                    chk("R2 R3 phase after report", 64'(phase), (seen == k) ? 2 : 1);
                    if (seen == 1 && k > 1) begin
                        done = N'(1 << i); tick(); done = '0; tick();
                        chk("R7 duplicate report", 64'(phase), 1);
                    end
                    if (seen == 1 && m != 15) begin
                        logic [N-1:0] off;
                        off = ~m[N-1:0];
                        done = off & (~off + 1'b1); tick(); done = '0; tick();
                        chk("R7 disabled core report", 64'(phase), (k == 1) ? 2 : 1);
                    end
                end
            end
            chk("R8 legal injections", 64'(err), 0);
            for (int d = 0; d < k; d++) begin
                dlv = 4'b0001; tick(); dlv = '0;
                chk("R4 drain holds", 64'(phase), 2);
            end
            tick();
            chk("R4 step after drain", 64'(phase), 3);
            chk("R5 advance vector", 64'(advance), 64'(m));
            chk("R6 timestep before step", 64'(timestep), 64'(exp_ts));
            done = m[N-1:0];
            tick();
            done = '0;
            exp_ts = exp_ts + 1;
            chk("R5 step one cycle", 64'(phase), 0);
            chk("R5 advance cleared", 64'(advance), 0);
            chk("R6 timestep", 64'(timestep), 64'(exp_ts));
            chk("R6 wrap", 64'(ts_w), 64'(exp_ts[2:0]));
            tick();
            chk("R7 report in step ignored", 64'(phase), 0);
        end

        // empty mask
        en = '0;
        tick();
        chk("R3 empty mask drains", 64'(phase), 2);
        tick();
        chk("R3 empty mask step", 64'(phase), 3);
        chk("R5 empty advance", 64'(advance), 0);
        en = 4'hF;
        tick();
        exp_ts = exp_ts + 1;
        chk("R6 empty mask timestep", 64'(timestep), 64'(exp_ts));
        chk("R6 empty mask wrap", 64'(ts_w), 64'(exp_ts[2:0]));

        // late injection
        done = 4'b0010; tick(); done = '0;
        inj = 4'b0001; tick(); inj = '0;
        chk("R8 injection before report", 64'(err), 0);
        inj = 4'b0010; tick(); inj = '0;
        chk("R8 late injection", 64'(err), 1);
        tick(); tick();
        chk("R8 sticky", 64'(err), 1);

        // underflow
        rst = 1'b1; tick(); rst = 1'b0; exp_ts = 0;
        chk("R1 error cleared", 64'(err), 0);
        dlv = 4'b0001; tick(); dlv = '0;
        chk("R9 underflow flag", 64'(err), 1);
        inj = 4'b0001; tick(); inj = '0;
        done = 4'hF; tick(); done = '0; tick();
        chk("R9 clamp holds drain", 64'(phase), 2);
        dlv = 4'b0001; tick(); dlv = '0; tick();
        chk("R9 clamp then step", 64'(phase), 3);
        chk("R6 timestep after reset", 64'(timestep), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule